// File: doc/BRIEF.md
# BCD 24-Hour Time Counter

This block keeps the time of day as six binary-coded-decimal digits: two for hours, two for minutes and two for seconds. All digits are registers on a single clock. A one-cycle tick-enable pulse, nominally once per second, moves the time forward by one second. A seconds wrap carries into the minutes, and a minutes wrap carries into the hours. After 23:59:59 the time returns to 00:00:00.

Two level inputs set the time by hand. While the minutes button is held, each tick adds one to the minutes. While the hours button is held, each tick adds one to the hours. The seconds keep running during a set, but their carry into the minutes is blocked. Each digit leaves the block as a 4-bit value whose bits weigh 1, 2, 4 and 8 starting from the least significant bit. A column of four lamps can show a digit directly.

Top module: `bcd_timekeeper`

## Requirements
- R1: A synchronous active-high reset sets all six digits to zero (00:00:00) on the next clock edge.
- R2: On a clock edge where tick_en is low, no digit changes, whatever the set buttons do.
- R3: Each tick advances the seconds. The units digit counts 0 to 9 and the tens digit counts 0 to 5. The step from 59 gives 00 and carries one into the minutes.
- R4: When the minutes are at 59 and receive a carry, they become 00 and carry one into the hours.
- R5: With no set button held, a tick at 23:59:59 gives 00:00:00.
- R6: While set_min_btn is held, each tick adds one to the minutes. The minutes wrap from 59 to 00 without changing the hours.
- R7: While set_hr_btn is held, each tick adds one to the hours. The hours wrap from 23 to 00 through both hour digits together.
- R8: While either set button is held, the seconds still advance on every tick, but a seconds wrap does not carry into the minutes.
- R9: Every digit is a 4-bit binary value of weight 1-2-4-8 from bit 0 upward. Units digits of seconds and minutes never exceed 9, and tens digits of seconds and minutes never exceed 5.
- R10: The hours tens digit never exceeds 2. The hours units digit never exceeds 3 while the hours tens digit is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-second advance strobe, one cycle wide |
| set_min_btn | input | 1 | Held to step the minutes on each tick |
| set_hr_btn | input | 1 | Held to step the hours on each tick |
| hr_tens | output | 4 | Hours tens digit |
| hr_units | output | 4 | Hours units digit |
| min_tens | output | 4 | Minutes tens digit |
| min_units | output | 4 | Minutes units digit |
| sec_tens | output | 4 | Seconds tens digit |
| sec_units | output | 4 | Seconds units digit |

## Verification
Two events can fall on the same tick.

The first pair is a seconds wrap and a manual set. The bench holds a set button on the tick where the seconds go from 59 to 00. It then checks that the minutes moved only by the set step (or did not move, for an hours set) and received no extra carry.

The second pair is the minutes set and the hours set, both held on one tick. Each field must advance once, and neither may carry into the other. The scoreboard model predicts each case from the requirements, and every tick is compared.

// File: rtl/bcd_time_pkg.sv
package bcd_time_pkg;
  localparam int DIGIT_W = 4;
  localparam int UNITS_LAST = 9;
  localparam int SIXTY_TENS_LAST = 5;
  localparam int HOUR_TENS_LAST = 2;
  localparam int HOUR_UNITS_AT_TOP = 3;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  typedef struct packed {
    bcd_digit_t tens;
    bcd_digit_t units;
  } bcd_pair_t;
endpackage

// File: rtl/bcd_mod_digit.sv
module bcd_mod_digit #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] LAST_V = W'(LAST);
  localparam logic [W-1:0] ONE_V  = W'(1);

  logic at_last;
  assign at_last = (q == LAST_V);
  assign wrap    = inc && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (inc) begin
      q <= at_last ? '0 : q + ONE_V;
    end
  end
endmodule

// File: rtl/bcd_sixty_pair.sv
module bcd_sixty_pair
  import bcd_time_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  output bcd_digit_t tens,
  output bcd_digit_t units,
  output logic       wrap
);
  logic units_wrap;

  bcd_mod_digit #(.W(DIGIT_W), .LAST(UNITS_LAST)) u_units (
    .clk (clk),
    .rst (rst),
    .inc (inc),
    .q   (units),
    .wrap(units_wrap)
  );

  bcd_mod_digit #(.W(DIGIT_W), .LAST(SIXTY_TENS_LAST)) u_tens (
    .clk (clk),
    .rst (rst),
    .inc (units_wrap),
    .q   (tens),
    .wrap(wrap)
  );
endmodule

// File: rtl/bcd_hour_pair.sv
module bcd_hour_pair
  import bcd_time_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  output bcd_digit_t tens,
  output bcd_digit_t units
);
  localparam bcd_digit_t TENS_TOP   = DIGIT_W'(HOUR_TENS_LAST);
  localparam bcd_digit_t UNITS_TOP  = DIGIT_W'(HOUR_UNITS_AT_TOP);
  localparam bcd_digit_t UNITS_LASTV = DIGIT_W'(UNITS_LAST);
  localparam bcd_digit_t ONE_V      = DIGIT_W'(1);

  logic day_end;
  logic units_end;

  assign day_end   = (tens == TENS_TOP) && (units == UNITS_TOP);
  assign units_end = (units == UNITS_LASTV);

  always_ff @(posedge clk) begin
    if (rst) begin
      tens  <= '0;
      units <= '0;
    end else if (inc) begin
      if (day_end) begin
        tens  <= '0;
        units <= '0;
      end else if (units_end) begin
        tens  <= tens + ONE_V;
        units <= '0;
      end else begin
        units <= units + ONE_V;
      end
    end
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import bcd_time_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                set_min_btn,
  input  logic                set_hr_btn,
  output logic [DIGIT_W-1:0]  hr_tens,
  output logic [DIGIT_W-1:0]  hr_units,
  output logic [DIGIT_W-1:0]  min_tens,
  output logic [DIGIT_W-1:0]  min_units,
  output logic [DIGIT_W-1:0]  sec_tens,
  output logic [DIGIT_W-1:0]  sec_units
);
  logic setting;
  logic sec_wrap;
  logic min_wrap;
  logic min_inc;
  logic hr_inc;

  assign setting = set_min_btn || set_hr_btn;

  bcd_sixty_pair u_sec (
    .clk  (clk),
    .rst  (rst),
    .inc  (tick_en),
    .tens (sec_tens),
    .units(sec_units),
    .wrap (sec_wrap)
  );

  // Manual set replaces the seconds carry; a set wrap never ripples upward.
  assign min_inc = tick_en && (set_min_btn || (sec_wrap && !setting));

  bcd_sixty_pair u_min (
    .clk  (clk),
    .rst  (rst),
    .inc  (min_inc),
    .tens (min_tens),
    .units(min_units),
    .wrap (min_wrap)
  );

  assign hr_inc = tick_en && (set_hr_btn || (min_wrap && !setting));

  bcd_hour_pair u_hr (
    .clk  (clk),
    .rst  (rst),
    .inc  (hr_inc),
    .tens (hr_tens),
    .units(hr_units)
  );
endmodule

// File: rtl/bcd_timekeeper_checker.sv
module bcd_timekeeper_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       set_min_btn,
  input logic       set_hr_btn,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_units,
  input logic [3:0] min_tens,
  input logic [3:0] min_units,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_units
);
  logic        rst_seen;
  logic [23:0] now;
  assign now = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      AST_RESET_ZERO: assert (now == 24'h0); // R1
    end
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(now)); // R2

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> (sec_units == (($past(sec_units) == 4'd9) ? 4'd0 : $past(sec_units) + 4'd1))); // R3

  AST_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !set_min_btn && !set_hr_btn && now == 24'h235959) |=> (now == 24'h0)); // R5

  AST_SET_MIN_KEEPS_HOURS: assert property (@(posedge clk) disable iff (rst)
    (tick_en && set_min_btn && !set_hr_btn) |=> $stable({hr_tens, hr_units})); // R6

  AST_SET_HR_KEEPS_MINUTES: assert property (@(posedge clk) disable iff (rst)
    (tick_en && set_hr_btn && !set_min_btn) |=> $stable({min_tens, min_units})); // R8

  AST_SIXTY_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sec_units <= 4'd9) && (min_units <= 4'd9) && (sec_tens <= 4'd5) && (min_tens <= 4'd5)); // R9

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (hr_tens <= 4'd2) && (hr_units <= 4'd9) && ((hr_tens != 4'd2) || (hr_units <= 4'd3))); // R10
endmodule

bind bcd_timekeeper bcd_timekeeper_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .set_min_btn(set_min_btn),
  .set_hr_btn (set_hr_btn),
  .hr_tens    (hr_tens),
  .hr_units   (hr_units),
  .min_tens   (min_tens),
  .min_units  (min_units),
  .sec_tens   (sec_tens),
  .sec_units  (sec_units)
);

// File: tb/tb_bcd_timekeeper.sv
module tb_bcd_timekeeper;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic set_min_btn = 1'b0;
  logic set_hr_btn = 1'b0;
  logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;

  int n_cmp = 0;
  int n_bad = 0;
  int hh = 0, mm = 0, ss = 0;
  bit finished = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_timekeeper dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .set_min_btn(set_min_btn), .set_hr_btn(set_hr_btn),
    .hr_tens(hr_tens), .hr_units(hr_units),
    .min_tens(min_tens), .min_units(min_units),
    .sec_tens(sec_tens), .sec_units(sec_units)
  );

  function automatic logic [23:0] pack_time(int h, int m, int s);
    return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10)};
  endfunction

  // Monitor: compares every queued expectation against the settled outputs.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [23:0] e;
      logic [23:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  // Driver: one clock edge with the given inputs, then pushes the model result.
  task automatic step(input bit tk, input bit sm, input bit sh, input string tag);
    bit carry_m, carry_h;
    @(negedge clk);
    tick_en = tk; set_min_btn = sm; set_hr_btn = sh;
    if (tk) begin
      carry_m = 1'b0; carry_h = 1'b0;
      ss = (ss + 1) % 60;
      if (ss == 0 && !sm && !sh) carry_m = 1'b1;
      if (sm) mm = (mm + 1) % 60;
      else if (carry_m) begin
        mm = (mm + 1) % 60;
        if (mm == 0) carry_h = 1'b1;
      end
      if (sh) hh = (hh + 1) % 24;
      else if (carry_h) hh = (hh + 1) % 24;
    end
    @(posedge clk);
    #1;
    exp_q.push_back(pack_time(hh, mm, ss));
    tag_q.push_back(tag);
    tick_en = 1'b0; set_min_btn = 1'b0; set_hr_btn = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    hh = 0; mm = 0; ss = 0;
    exp_q.push_back(24'h0);
    tag_q.push_back(tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset("R1 reset");
    // R2: set buttons without tick leave the time unchanged
    step(1'b1, 1'b0, 1'b0, "R3 first tick");
    for (int i = 0; i < 4; i++) step(1'b0, i[0], i[1], "R2 no tick");
    // R3: seconds roll through 59 into minutes
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0, "R3 seconds");
    // R7: set hours to 23, then wrap 23 -> 00 and back to 23
    for (int i = 0; i < 23; i++) step(1'b1, 1'b0, 1'b1, "R7 set hours");
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, 1'b1, "R7 hours wrap");
    // R6: set minutes to 59, then wrap without touching hours
    while (mm != 59) step(1'b1, 1'b1, 1'b0, "R6 set minutes");
    step(1'b1, 1'b1, 1'b0, "R6 minute wrap");
    while (mm != 59) step(1'b1, 1'b1, 1'b0, "R6 set minutes");
    // R8: seconds wrap under a held set button gives no extra carry
    while (ss != 59) step(1'b1, 1'b0, 1'b0, "R3 seconds");
    step(1'b1, 1'b0, 1'b1, "R8 wrap during hour set");
    while (ss != 59) step(1'b1, 1'b0, 1'b0, "R3 seconds");
    step(1'b1, 1'b1, 1'b0, "R8 wrap during minute set");
    step(1'b1, 1'b1, 1'b1, "R8 both sets held");
    // R4 / R5: walk to 23:59:59 and roll over
    while (hh != 23) step(1'b1, 1'b0, 1'b1, "R7 set hours");
    while (mm != 59) step(1'b1, 1'b1, 1'b0, "R6 set minutes");
    while (ss != 59) step(1'b1, 1'b0, 1'b0, "R3 seconds");
    step(1'b1, 1'b0, 1'b0, "R5 midnight");
    while (hh != 9) step(1'b1, 1'b0, 1'b1, "R7 set hours");
    while (mm != 59) step(1'b1, 1'b1, 1'b0, "R6 set minutes");
    while (ss != 59) step(1'b1, 1'b0, 1'b0, "R3 seconds");
    step(1'b1, 1'b0, 1'b0, "R4 hour carry into tens R9 R10");
    do_reset("R1 reset from nonzero");
    step(1'b0, 1'b0, 1'b0, "R2 idle after reset");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule